// File: doc/BRIEF.md
# ECC Error Logging Register Unit

This unit sits beside a DRAM datapath's error-correction decoder and records ECC failures where software can see them. The decoder signals each failing transaction with a one-cycle pulse, one for a correctable error and one for an uncorrectable error. The pulse comes with the failing physical address, an 8-bit syndrome and a channel index. The unit keeps one sticky flag per error class. It also keeps one captured set of error data: the 4 KiB page address, the syndrome and the channel.

Capture follows a severity rule. An uncorrectable error replaces data taken from a correctable one. Nothing replaces data taken from an uncorrectable one. While any flag is pending, a new correctable error is only recorded in its flag.

Software reaches the unit over a plain word-indexed register bus. Reads are combinational and writes take effect in one cycle. Software clears a flag by writing a one to its bit. A command register holds two enables. The system error output is a level that stays high while an enabled flag is pending.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero and `sys_err` is low.
- R2: The status register is at word index 0. A correctable pulse sets status bit 0 and an uncorrectable pulse sets status bit 7 on the next clock edge. All other status bits read zero.
- R3: Writing status with a 1 in bit 0 or bit 7 clears that flag. A 0 in that bit leaves the flag unchanged. Writes to other status bits have no effect.
- R4: If a pulse and a write-one-to-clear of the same flag fall in the same cycle, the flag ends up set.
- R5: The address register is at word index 2. It holds bits 31:12 of the captured failing address, and bits 11:0 read zero.
- R6: The syndrome register (word index 3) holds the 8-bit captured syndrome. The channel register (word index 4) holds the captured channel in bit 0, with all other bits zero. The address, syndrome and channel registers ignore bus writes.
- R7: An uncorrectable pulse while only the correctable flag is set replaces the address, syndrome and channel with the uncorrectable error's values. It also sets bit 7, and bit 0 stays set.
- R8: While either flag is set, a correctable pulse leaves the captured data unchanged. While the uncorrectable flag is set, an uncorrectable pulse also leaves it unchanged.
- R9: Simultaneous correctable and uncorrectable pulses with no flag pending capture the uncorrectable error's data and set both flags.
- R10: The command register is at word index 1. Bit 8 enables the system error for uncorrectable errors and bit 7 enables it for correctable errors. Other bits read zero and ignore writes.
- R11: `sys_err` is high exactly while (status bit 7 AND command bit 8) OR (status bit 0 AND command bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable error pulse |
| ue_evt | input | 1 | Uncorrectable error pulse |
| evt_addr | input | 32 | Failing physical address |
| evt_syn | input | 8 | ECC syndrome of the failing access |
| evt_chan | input | 1 | Channel of the failing access |
| bus_sel | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| sys_err | output | 1 | System error level |

## Verification
The hardest case to reach is a collision in a single cycle. A hardware pulse must arrive in the same cycle as a software write-one-to-clear of the same flag. Other pulses must arrive in the same cycle as each other.

The bench drives these collisions directly. It puts an event pulse and a status-write strobe into the same half-period, for each flag in turn. It also fires both pulses together, each carrying different data, so that the captured data shows which one won. Priority is tested with event sequences that leave a flag pending. Each later pulse carries fresh values, so an overwrite that should not happen shows up in the address, syndrome or channel register.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    REG_STATUS  = 3'd0,
    REG_COMMAND = 3'd1,
    REG_ADDRESS = 3'd2,
    REG_SYND    = 3'd3,
    REG_CHAN    = 3'd4
  } reg_sel_e;

  // Bit positions that software and the alert logic decode.
  localparam int unsigned STS_CE_BIT = 0;
  localparam int unsigned STS_UE_BIT = 7;
  localparam int unsigned CMD_CE_BIT = 7;
  localparam int unsigned CMD_UE_BIT = 8;
endpackage

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned SYN_W    = 8,
  localparam int unsigned PAGE_W  = ADDR_W - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic              evt_chan,
  input  logic              clr_ce,
  input  logic              clr_ue,
  output logic              ce_flag,
  output logic              ue_flag,
  output logic [PAGE_W-1:0] log_page,
  output logic [SYN_W-1:0]  log_syn,
  output logic              log_chan
);
  logic              ce_q, ce_d, ue_q, ue_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [SYN_W-1:0]  syn_q, syn_d;
  logic              chan_q, chan_d;
  logic              take_ue, take_ce, load_en;
  logic [PAGE_LSB-1:0] unused_low;

  assign unused_low = evt_addr[PAGE_LSB-1:0];

  always_comb begin
    // Severity rule: UE data lands unless a UE is pending; CE data only into an empty log.
    take_ue = ue_evt & ~ue_q;
    take_ce = ce_evt & ~ce_q & ~ue_q & ~ue_evt;
    load_en = take_ue | take_ce;
    // A new capture overrides a clear in the same cycle.
    ce_d = ce_evt | (ce_q & ~clr_ce);
    ue_d = ue_evt | (ue_q & ~clr_ue);
    page_d = page_q;
    syn_d  = syn_q;
    chan_d = chan_q;
    if (load_en) begin
      page_d = evt_addr[ADDR_W-1:PAGE_LSB];
      syn_d  = evt_syn;
      chan_d = evt_chan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b0;
      ue_q <= 1'b0;
    end else begin
      ce_q <= ce_d;
      ue_q <= ue_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      syn_q  <= '0;
      chan_q <= 1'b0;
    end else if (load_en) begin
      page_q <= page_d;
      syn_q  <= syn_d;
      chan_q <= chan_d;
    end
  end

  assign ce_flag  = ce_q;
  assign ue_flag  = ue_q;
  assign log_page = page_q;
  assign log_syn  = syn_q;
  assign log_chan = chan_q;

  // R4: a pulse always leaves its flag set on the next edge.
  assert_ce_pulse_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt |=> ce_q);
  assert_ue_pulse_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt |=> ue_q);
  // R3: clear without a competing pulse drops the flag.
  assert_ce_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ce && !ce_evt) |=> !ce_q);
  // R8: a pending UE freezes the captured data.
  assert_ue_holds_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ue_q |=> ($stable(page_q) && $stable(syn_q) && $stable(chan_q)));
  // R8: a pending CE freezes data unless a UE arrives.
  assert_ce_holds_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && !ue_evt) |=> ($stable(page_q) && $stable(syn_q)));
  // R7: UE over a logged CE takes the UE data and keeps the CE flag.
  assert_ue_overwrites_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !ue_q && ce_q && !clr_ce) |=> (ce_q && syn_q == $past(evt_syn)));
endmodule

// File: rtl/ecc_log_cmd.sv
module ecc_log_cmd #(
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wdata,
  output logic             en_ce,
  output logic             en_ue
);
  import ecc_log_pkg::*;

  logic en_ce_q, en_ce_d, en_ue_q, en_ue_d;

  always_comb begin
    en_ce_d = wdata[CMD_CE_BIT];
    en_ue_d = wdata[CMD_UE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ce_q <= 1'b0;
      en_ue_q <= 1'b0;
    end else if (wr_en) begin
      en_ce_q <= en_ce_d;
      en_ue_q <= en_ue_d;
    end
  end

  assign en_ce = en_ce_q;
  assign en_ue = en_ue_q;

  // R10: enables move only on a command write.
  assert_cmd_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_ce_q) && $stable(en_ue_q)));
endmodule

// File: rtl/ecc_log_alert.sv
module ecc_log_alert (
  input  logic ce_flag,
  input  logic ue_flag,
  input  logic en_ce,
  input  logic en_ue,
  output logic sys_err
);
  always_comb begin
    sys_err = (ce_flag & en_ce) | (ue_flag & en_ue);
  end

  // R11: no alert without a pending flag.
  always_comb begin
    if (!ce_flag && !ue_flag)
      assert_no_idle_alert_R11: assert (!sys_err);
  end
endmodule

// File: rtl/ecc_log_rdmux.sv
module ecc_log_rdmux #(
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned SYN_W    = 8,
  localparam int unsigned PAGE_W  = ADDR_W - PAGE_LSB
) (
  input  logic [ecc_log_pkg::SEL_W-1:0] sel,
  input  logic              ce_flag,
  input  logic              ue_flag,
  input  logic              en_ce,
  input  logic              en_ue,
  input  logic [PAGE_W-1:0] log_page,
  input  logic [SYN_W-1:0]  log_syn,
  input  logic              log_chan,
  output logic [BUS_W-1:0]  rdata
);
  import ecc_log_pkg::*;

  logic [BUS_W-1:0] sts_w, cmd_w, adr_w, syn_w, chn_w;

  always_comb begin
    sts_w = '0;
    sts_w[STS_CE_BIT] = ce_flag;
    sts_w[STS_UE_BIT] = ue_flag;
    cmd_w = '0;
    cmd_w[CMD_CE_BIT] = en_ce;
    cmd_w[CMD_UE_BIT] = en_ue;
    adr_w = '0;
    adr_w[ADDR_W-1:PAGE_LSB] = log_page;
    syn_w = '0;
    syn_w[SYN_W-1:0] = log_syn;
    chn_w = '0;
    chn_w[0] = log_chan;
  end

  always_comb begin
    case (sel)
      REG_STATUS:  rdata = sts_w;
      REG_COMMAND: rdata = cmd_w;
      REG_ADDRESS: rdata = adr_w;
      REG_SYND:    rdata = syn_w;
      REG_CHAN:    rdata = chn_w;
      default:     rdata = '0;
    endcase
  end

  // R2: status reads show at most the two flag bits.
  always_comb begin
    if (sel == REG_STATUS)
      assert_status_reserved_R2: assert ($countones(rdata) <= 2 &&
        rdata[STS_UE_BIT-1:STS_CE_BIT+1] == '0);
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned SYN_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ce_evt,
  input  logic                          ue_evt,
  input  logic [ADDR_W-1:0]             evt_addr,
  input  logic [SYN_W-1:0]              evt_syn,
  input  logic                          evt_chan,
  input  logic [ecc_log_pkg::SEL_W-1:0] bus_sel,
  input  logic                          bus_wr,
  input  logic [BUS_W-1:0]              bus_wdata,
  output logic [BUS_W-1:0]              bus_rdata,
  output logic                          sys_err
);
  import ecc_log_pkg::*;

  localparam int unsigned PAGE_W = ADDR_W - PAGE_LSB;

  logic              wr_sts, wr_cmd, clr_ce, clr_ue;
  logic              ce_flag, ue_flag, en_ce, en_ue, log_chan;
  logic [PAGE_W-1:0] log_page;
  logic [SYN_W-1:0]  log_syn;

  always_comb begin
    wr_sts = bus_wr & (bus_sel == REG_STATUS);
    wr_cmd = bus_wr & (bus_sel == REG_COMMAND);
    clr_ce = wr_sts & bus_wdata[STS_CE_BIT];
    clr_ue = wr_sts & bus_wdata[STS_UE_BIT];
  end

  ecc_log_capture #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .SYN_W(SYN_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .evt_addr(evt_addr), .evt_syn(evt_syn), .evt_chan(evt_chan),
    .clr_ce(clr_ce), .clr_ue(clr_ue), .ce_flag(ce_flag), .ue_flag(ue_flag),
    .log_page(log_page), .log_syn(log_syn), .log_chan(log_chan)
  );

  ecc_log_cmd #(.BUS_W(BUS_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmd), .wdata(bus_wdata),
    .en_ce(en_ce), .en_ue(en_ue)
  );

  ecc_log_alert u_alert (
    .ce_flag(ce_flag), .ue_flag(ue_flag), .en_ce(en_ce), .en_ue(en_ue),
    .sys_err(sys_err)
  );

  ecc_log_rdmux #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .SYN_W(SYN_W)) u_rdmux (
    .sel(bus_sel), .ce_flag(ce_flag), .ue_flag(ue_flag), .en_ce(en_ce), .en_ue(en_ue),
    .log_page(log_page), .log_syn(log_syn), .log_chan(log_chan), .rdata(bus_rdata)
  );

  // R1: outputs are quiet in the cycle after reset release.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !sys_err);
  // R11: an enabled pending UE raises the alert.
  assert_ue_alert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_flag && en_ue) |-> sys_err);
endmodule

// File: tb/ecc_err_log_bench.sv
module ecc_err_log_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_evt, ue_evt, evt_chan, bus_wr;
  logic [31:0] evt_addr, bus_wdata, bus_rdata;
  logic [7:0]  evt_syn;
  logic [2:0]  bus_sel;
  logic        sys_err;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  typedef struct {
    logic        is_alert;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  ecc_err_log u_ecc_err_log (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .evt_addr(evt_addr), .evt_syn(evt_syn), .evt_chan(evt_chan),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_err(sys_err)
  );

  // Monitor: pops each expected item and compares against the live port.
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_alert ? {31'd0, sys_err} : bus_rdata;
        vectors++;
        if (act !== it.exp) begin
          misses++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      misses++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic expect_reg(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = sel;
    #1;
    it.is_alert = 1'b0; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic expect_alert(input logic exp, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.is_alert = 1'b1; it.exp = {31'd0, exp}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic pulse(input logic ce, input logic ue, input logic [31:0] a,
                       input logic [7:0] s, input logic ch);
    @(negedge clk);
    ce_evt = ce; ue_evt = ue; evt_addr = a; evt_syn = s; evt_chan = ch;
    @(negedge clk);
    ce_evt = 1'b0; ue_evt = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic collide(input logic ce, input logic ue, input logic [31:0] a,
                         input logic [7:0] s, input logic [31:0] clr);
    @(negedge clk);
    ce_evt = ce; ue_evt = ue; evt_addr = a; evt_syn = s; evt_chan = 1'b1;
    bus_sel = 3'd0; bus_wr = 1'b1; bus_wdata = clr;
    @(negedge clk);
    ce_evt = 1'b0; ue_evt = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic expect_log(input logic [31:0] a, input logic [7:0] s,
                            input logic ch, input string tag);
    expect_reg(3'd2, a, {tag, " addr"});
    expect_reg(3'd3, {24'd0, s}, {tag, " syn"});
    expect_reg(3'd4, {31'd0, ch}, {tag, " chan"});
  endtask

  initial begin
    rst_n = 1'b0; ce_evt = 0; ue_evt = 0; evt_chan = 0; bus_wr = 0;
    evt_addr = '0; evt_syn = '0; bus_sel = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 5; i++) expect_reg(i[2:0], 32'h0, "R1 reset reg");
    expect_alert(1'b0, "R1 reset sys_err");

    // R2, R5, R6: first CE is captured
    pulse(1, 0, 32'h1234_5ABC, 8'h3C, 1'b1);
    expect_reg(3'd0, 32'h0000_0001, "R2 ce flag");
    expect_log(32'h1234_5000, 8'h3C, 1'b1, "R5 R6 ce capture");

    // R8: second CE does not overwrite
    pulse(1, 0, 32'hAAAA_A000, 8'h11, 1'b0);
    expect_log(32'h1234_5000, 8'h3C, 1'b1, "R8 ce over ce");

    // R7: UE overwrites CE data, CE bit stays
    pulse(0, 1, 32'h8765_4321, 8'hF0, 1'b0);
    expect_reg(3'd0, 32'h0000_0081, "R7 both flags");
    expect_log(32'h8765_4000, 8'hF0, 1'b0, "R7 ue capture");

    // R8: UE over UE and CE over UE leave data alone
    pulse(0, 1, 32'h0000_1FFF, 8'h77, 1'b1);
    expect_log(32'h8765_4000, 8'hF0, 1'b0, "R8 ue over ue");
    pulse(1, 0, 32'hFFFF_F000, 8'h55, 1'b1);
    expect_log(32'h8765_4000, 8'hF0, 1'b0, "R8 ce over ue");

    // R6: captured registers ignore writes
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    expect_log(32'h8765_4000, 8'hF0, 1'b0, "R6 read-only");

    // R10: command register
    expect_alert(1'b0, "R11 no enables");
    wr(3'd1, 32'hFFFF_FFFF);
    expect_reg(3'd1, 32'h0000_0180, "R10 command bits");
    expect_alert(1'b1, "R11 enabled");

    // R3: write-one-to-clear
    wr(3'd0, 32'h0000_0000);
    expect_reg(3'd0, 32'h0000_0081, "R3 zero write");
    wr(3'd0, 32'h0000_0080);
    expect_reg(3'd0, 32'h0000_0001, "R3 clear ue");
    expect_alert(1'b1, "R11 ce enabled");
    wr(3'd1, 32'h0000_0100);
    expect_alert(1'b0, "R11 ce disabled");
    wr(3'd0, 32'hFFFF_FF7E);
    expect_reg(3'd0, 32'h0000_0001, "R3 reserved write");
    wr(3'd0, 32'h0000_0001);
    expect_reg(3'd0, 32'h0000_0000, "R3 clear ce");

    // R4: capture beats clear in the same cycle
    collide(1, 0, 32'h0BAD_0000, 8'h21, 32'h0000_0001);
    expect_reg(3'd0, 32'h0000_0001, "R4 ce vs clear");
    expect_reg(3'd2, 32'h0BAD_0000, "R4 ce data");
    collide(0, 1, 32'h0C0D_E000, 8'h42, 32'h0000_0080);
    expect_reg(3'd0, 32'h0000_0081, "R4 ue vs clear");
    expect_alert(1'b1, "R11 ue enabled");

    // R9: simultaneous CE and UE
    wr(3'd0, 32'h0000_0081);
    expect_reg(3'd0, 32'h0000_0000, "R3 clear both");
    expect_alert(1'b0, "R11 idle");
    @(negedge clk);
    ce_evt = 1; ue_evt = 1; evt_addr = 32'hDEAD_BEEF; evt_syn = 8'h99; evt_chan = 1;
    @(negedge clk);
    ce_evt = 0; ue_evt = 0;
    expect_reg(3'd0, 32'h0000_0081, "R9 both flags");
    expect_log(32'hDEAD_B000, 8'h99, 1'b1, "R9 ue data");
    wr(3'd1, 32'h0000_0000);
    expect_alert(1'b0, "R11 all disabled");
    expect_reg(3'd5, 32'h0, "R10 unmapped index");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule